// File: doc/BRIEF.md
# SGMII / Fiber Mode Autodetect

This block decides whether a serial Ethernet lane runs in SGMII mode or in fiber (clause 37) mode. It watches the auto-negotiation pages handed over by the page receiver. Bit 0 of each page is the selector, and a value of 1 marks an SGMII page. With autodetect turned on, a page whose selector disagrees with the current mode flips the mode. With autodetect turned off, a static configuration bit sets the mode. Every change of mode sends a single-cycle restart request to the negotiation logic.

In SGMII mode the block decodes the partner's link, acknowledge, duplex and speed fields from each SGMII page and presents them as registered outputs. It gates the signal-detect input, which only counts in fiber mode. Two sticky flags record events until a clear pulse. One records that the mode changed. The other records that a non-SGMII page arrived while the lane was in SGMII mode.

Top module: `lane_mode_detect`

## Requirements
- R1: With `autodet_en` low, `mode_sgmii` equals the inverse of `fiber_cfg` one clock later (fiber_cfg 0 selects SGMII, 1 selects fiber). Received pages do not change the mode.
- R2: With `autodet_en` high, an accepted page whose bit 0 differs from `mode_sgmii` toggles the mode on the next clock. A page whose bit 0 matches leaves the mode unchanged, and `fiber_cfg` has no effect.
- R3: `restart_req` is high for exactly the one cycle in which a new mode first shows on `mode_sgmii`, and it is low otherwise.
- R4: `mode_chg_flag` sets on every mode change and stays set until it is cleared.
- R5: `sel_mis_flag` sets one clock after an accepted page with bit 0 equal to 0 while `mode_sgmii` is 1. This happens whether or not autodetect is on, and the flag stays set until it is cleared.
- R6: A `flags_clr` pulse clears both flags on the next clock. If a set event and a clear fall in the same cycle, the set wins.
- R7: In SGMII mode, an accepted page with bit 0 equal to 1 is decoded one clock later. Bit 15 drives `part_link`, bit 14 drives `part_ack`, bit 12 drives `part_duplex` and bits 11:10 drive `part_speed`.
- R8: The speed codes are 00 for 10 Mb/s, 01 for 100 Mb/s and 10 for 1000 Mb/s, and each of these sets `speed_valid`. The reserved code 11 is reported unchanged on `part_speed` with `speed_valid` low.
- R9: Whenever `mode_sgmii` is 0, all decoded partner outputs and `speed_valid` are 0.
- R10: `sig_det_ok` is 1 in SGMII mode whatever `sig_det` is. In fiber mode it follows `sig_det` one clock later.
- R11: While `rst` is high, the block sets `mode_sgmii` to the inverse of `fiber_cfg` and drives both flags, `restart_req` and all decoded outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| autodet_en | input | 1 | Enables mode selection from page selector bits |
| fiber_cfg | input | 1 | Static mode choice when autodetect is off (1 = fiber) |
| flags_clr | input | 1 | Clears both sticky flags |
| page_valid | input | 1 | A received page is presented this cycle |
| page_word | input | 16 | Received auto-negotiation page |
| sig_det | input | 1 | Raw signal-detect input |
| mode_sgmii | output | 1 | Current mode, 1 = SGMII, 0 = fiber |
| restart_req | output | 1 | One-cycle negotiation restart request on a mode change |
| part_link | output | 1 | Partner link status |
| part_ack | output | 1 | Partner acknowledge |
| part_duplex | output | 1 | Partner duplex, 1 = full |
| part_speed | output | 2 | Partner speed code |
| speed_valid | output | 1 | Speed code is not the reserved value |
| sig_det_ok | output | 1 | Gated signal-detect |
| mode_chg_flag | output | 1 | Sticky mode-change flag |
| sel_mis_flag | output | 1 | Sticky selector-mismatch flag |

## Verification
The hardest cases to reach are the ones where several effects land on the same edge. One is a selector-mismatch page arriving in the cycle of a flag clear. Another is a mismatched page under autodetect that must flip the mode, pulse the restart, set both flags and wipe the decoded fields, all on one clock. The bench first puts the lane in SGMII mode through the configuration bit with autodetect off. It then enables autodetect and feeds pages of alternating selector, so that each of these edges is reached from a known state. A page whose selector matches the current mode, and a configuration change made while autodetect is on, show that nothing moves when it should not.

// File: rtl/lmd_pkg.sv
package lmd_pkg;
  localparam int PAGE_W  = 16;
  localparam int SEL_BIT = 0;
  localparam int DUP_BIT = 12;
  localparam int ACK_BIT = 14;
  localparam int LNK_BIT = 15;
  localparam int SPD_LO  = 10;
  localparam int SPD_W   = 2;

  typedef enum logic [SPD_W-1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_RSVD = 2'b11
  } speed_e;

  typedef struct packed {
    logic   link;
    logic   ack;
    logic   duplex;
    speed_e speed;
    logic   speed_ok;
  } partner_t;

  localparam int NFLAG    = 2;
  localparam int FLAG_CHG = 0;
  localparam int FLAG_MIS = 1;
endpackage

// File: rtl/lmd_mode_ctrl.sv
module lmd_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic autodet_en,
  input  logic fiber_cfg,
  input  logic page_valid,
  input  logic page_sel,
  output logic mode_cur,
  output logic mode_nxt,
  output logic changed,
  output logic restart_req
);
  always_comb begin
    if (rst)
      mode_nxt = ~fiber_cfg;
    else if (!autodet_en)
      mode_nxt = ~fiber_cfg;
    else if (page_valid && (page_sel != mode_cur))
      mode_nxt = ~mode_cur;
    else
      mode_nxt = mode_cur;
  end

  assign changed = ~rst & (mode_nxt ^ mode_cur);

  always_ff @(posedge clk) begin
    mode_cur <= mode_nxt;
    if (rst) restart_req <= 1'b0;
    else     restart_req <= changed;
  end
endmodule

// File: rtl/lmd_partner_dec.sv
module lmd_partner_dec
  import lmd_pkg::*;
#(
  parameter int W = PAGE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_cur,
  input  logic          mode_nxt,
  input  logic          page_valid,
  input  logic [W-1:0]  page_word,
  output partner_t      partner
);
  logic [SPD_W-1:0] spd_raw;
  logic             take;

  assign spd_raw = page_word[SPD_LO +: SPD_W];
  assign take    = page_valid & page_word[SEL_BIT] & mode_cur;

  always_ff @(posedge clk) begin
    if (rst || !mode_nxt) begin
      partner <= '0;
    end else if (take) begin
      partner.link     <= page_word[LNK_BIT];
      partner.ack      <= page_word[ACK_BIT];
      partner.duplex   <= page_word[DUP_BIT];
      partner.speed    <= speed_e'(spd_raw);
      partner.speed_ok <= (speed_e'(spd_raw) != SPD_RSVD);
    end
  end
endmodule

// File: rtl/lmd_sticky.sv
module lmd_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/lane_mode_detect.sv
module lane_mode_detect
  import lmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              autodet_en,
  input  logic              fiber_cfg,
  input  logic              flags_clr,
  input  logic              page_valid,
  input  logic [PAGE_W-1:0] page_word,
  input  logic              sig_det,
  output logic              mode_sgmii,
  output logic              restart_req,
  output logic              part_link,
  output logic              part_ack,
  output logic              part_duplex,
  output logic [SPD_W-1:0]  part_speed,
  output logic              speed_valid,
  output logic              sig_det_ok,
  output logic              mode_chg_flag,
  output logic              sel_mis_flag
);
  logic             mode_nxt;
  logic             changed;
  partner_t         partner;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_q;

  lmd_mode_ctrl i_mode (
    .clk        (clk),
    .rst        (rst),
    .autodet_en (autodet_en),
    .fiber_cfg  (fiber_cfg),
    .page_valid (page_valid),
    .page_sel   (page_word[SEL_BIT]),
    .mode_cur   (mode_sgmii),
    .mode_nxt   (mode_nxt),
    .changed    (changed),
    .restart_req(restart_req)
  );

  lmd_partner_dec #(.W(PAGE_W)) i_dec (
    .clk        (clk),
    .rst        (rst),
    .mode_cur   (mode_sgmii),
    .mode_nxt   (mode_nxt),
    .page_valid (page_valid),
    .page_word  (page_word),
    .partner    (partner)
  );

  assign flag_set[FLAG_CHG] = changed;
  assign flag_set[FLAG_MIS] = page_valid & ~page_word[SEL_BIT] & mode_sgmii;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    lmd_sticky i_flag (
      .clk (clk),
      .rst (rst),
      .set (flag_set[g]),
      .clr (flags_clr),
      .q   (flag_q[g])
    );
  end

  // signal detect only qualifies the link in fiber mode
  always_ff @(posedge clk) begin
    sig_det_ok <= mode_nxt | sig_det;
  end

  assign mode_chg_flag = flag_q[FLAG_CHG];
  assign sel_mis_flag  = flag_q[FLAG_MIS];
  assign part_link     = partner.link;
  assign part_ack      = partner.ack;
  assign part_duplex   = partner.duplex;
  assign part_speed    = partner.speed;
  assign speed_valid   = partner.speed_ok;
endmodule

// File: rtl/lmd_checker.sv
module lmd_checker (
  input logic        clk,
  input logic        rst,
  input logic        autodet_en,
  input logic        fiber_cfg,
  input logic        flags_clr,
  input logic        page_valid,
  input logic [15:0] page_word,
  input logic        mode_sgmii,
  input logic        restart_req,
  input logic        part_link,
  input logic        part_ack,
  input logic        part_duplex,
  input logic [1:0]  part_speed,
  input logic        speed_valid,
  input logic        sig_det_ok,
  input logic        mode_chg_flag,
  input logic        sel_mis_flag
);
  // R1
  cfg_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !autodet_en |=> (mode_sgmii == !$past(fiber_cfg)));
  // R2
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (autodet_en && !page_valid) |=> $stable(mode_sgmii));
  // R2
  toggle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (autodet_en && page_valid && (page_word[0] != mode_sgmii)) |=> (mode_sgmii != $past(mode_sgmii)));
  // R3
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart_req |-> (mode_sgmii != $past(mode_sgmii)));
  // R4
  chg_set_chk: assert property (@(posedge clk) disable iff (rst)
    restart_req |-> mode_chg_flag);
  // R4
  chg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_chg_flag && !flags_clr) |=> mode_chg_flag);
  // R5
  mis_set_chk: assert property (@(posedge clk) disable iff (rst)
    (page_valid && !page_word[0] && mode_sgmii) |=> sel_mis_flag);
  // R6
  mis_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_clr && !(page_valid && !page_word[0] && mode_sgmii)) |=> !sel_mis_flag);
  // R8
  rsvd_speed_chk: assert property (@(posedge clk) disable iff (rst)
    (part_speed == 2'b11) |-> !speed_valid);
  // R9
  fiber_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_sgmii |-> (!part_link && !part_ack && !part_duplex && part_speed == 2'b00 && !speed_valid));
  // R10
  sigdet_chk: assert property (@(posedge clk) disable iff (rst)
    mode_sgmii |-> sig_det_ok);
endmodule

bind lane_mode_detect lmd_checker i_chk (
  .clk          (clk),
  .rst          (rst),
  .autodet_en   (autodet_en),
  .fiber_cfg    (fiber_cfg),
  .flags_clr    (flags_clr),
  .page_valid   (page_valid),
  .page_word    (page_word),
  .mode_sgmii   (mode_sgmii),
  .restart_req  (restart_req),
  .part_link    (part_link),
  .part_ack     (part_ack),
  .part_duplex  (part_duplex),
  .part_speed   (part_speed),
  .speed_valid  (speed_valid),
  .sig_det_ok   (sig_det_ok),
  .mode_chg_flag(mode_chg_flag),
  .sel_mis_flag (sel_mis_flag)
);

// File: tb/test_lane_mode_detect.sv
`timescale 1ns/1ps
module test_lane_mode_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        autodet_en = 1'b0;
  logic        fiber_cfg = 1'b1;
  logic        flags_clr = 1'b0;
  logic        page_valid = 1'b0;
  logic [15:0] page_word = '0;
  logic        sig_det = 1'b0;
  logic        mode_sgmii, restart_req, part_link, part_ack, part_duplex;
  logic [1:0]  part_speed;
  logic        speed_valid, sig_det_ok, mode_chg_flag, sel_mis_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_mode_detect i_lane_mode_detect (
    .clk(clk), .rst(rst), .autodet_en(autodet_en), .fiber_cfg(fiber_cfg),
    .flags_clr(flags_clr), .page_valid(page_valid), .page_word(page_word),
    .sig_det(sig_det), .mode_sgmii(mode_sgmii), .restart_req(restart_req),
    .part_link(part_link), .part_ack(part_ack), .part_duplex(part_duplex),
    .part_speed(part_speed), .speed_valid(speed_valid), .sig_det_ok(sig_det_ok),
    .mode_chg_flag(mode_chg_flag), .sel_mis_flag(sel_mis_flag)
  );

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_page(input logic [15:0] w);
    page_valid = 1'b1;
    page_word  = w;
    tick();
    page_valid = 1'b0;
    page_word  = '0;
  endtask

  task automatic clear_flags();
    flags_clr = 1'b1;
    tick();
    flags_clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R11 mode in reset", mode_sgmii, 0);
    chk("R11 restart in reset", restart_req, 0);
    chk("R11 chg flag in reset", mode_chg_flag, 0);
    chk("R11 mis flag in reset", sel_mis_flag, 0);
    chk("R11 link in reset", part_link, 0);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_cfg_mode();
    fiber_cfg = 1'b0;
    tick();
    chk("R1 cfg selects sgmii", mode_sgmii, 1);
    chk("R3 restart pulse", restart_req, 1);
    chk("R4 chg flag set", mode_chg_flag, 1);
    tick();
    chk("R3 restart one cycle", restart_req, 0);
    chk("R4 chg flag held", mode_chg_flag, 1);
    chk("R10 sigdet ignored in sgmii", sig_det_ok, 1);
    send_page(16'h0000);
    chk("R1 page ignored without autodet", mode_sgmii, 1);
    chk("R5 mismatch flag set", sel_mis_flag, 1);
    chk("R3 no restart without change", restart_req, 0);
  endtask

  task automatic t_clear();
    clear_flags();
    chk("R6 chg cleared", mode_chg_flag, 0);
    chk("R6 mis cleared", sel_mis_flag, 0);
    flags_clr = 1'b1;
    send_page(16'h0000);
    flags_clr = 1'b0;
    chk("R6 set wins over clear", sel_mis_flag, 1);
    chk("R6 chg stays clear", mode_chg_flag, 0);
    clear_flags();
  endtask

  task automatic t_decode();
    send_page(16'hD801);
    chk("R7 link", part_link, 1);
    chk("R7 ack", part_ack, 1);
    chk("R7 duplex", part_duplex, 1);
    chk("R8 speed 1000", part_speed, 2);
    chk("R8 speed valid 1000", speed_valid, 1);
    chk("R5 sgmii page no mismatch", sel_mis_flag, 0);
    send_page(16'h0401);
    chk("R7 link low", part_link, 0);
    chk("R8 speed 100", part_speed, 1);
    chk("R8 speed valid 100", speed_valid, 1);
    send_page(16'h0C01);
    chk("R8 reserved code raw", part_speed, 3);
    chk("R8 reserved not valid", speed_valid, 0);
    send_page(16'h1001);
    chk("R8 speed 10", part_speed, 0);
    chk("R8 speed valid 10", speed_valid, 1);
    chk("R7 duplex only", part_duplex, 1);
  endtask

  task automatic t_fiber();
    send_page(16'hD801);
    fiber_cfg = 1'b1;
    sig_det = 1'b0;
    tick();
    chk("R1 cfg selects fiber", mode_sgmii, 0);
    chk("R9 link cleared in fiber", part_link, 0);
    chk("R9 speed valid cleared in fiber", speed_valid, 0);
    chk("R10 sigdet low in fiber", sig_det_ok, 0);
    sig_det = 1'b1;
    tick();
    chk("R10 sigdet high in fiber", sig_det_ok, 1);
    sig_det = 1'b0;
    tick();
    chk("R10 sigdet follows in fiber", sig_det_ok, 0);
  endtask

  task automatic t_autodet();
    autodet_en = 1'b1;
    tick();
    clear_flags();
    chk("R2 no page no change", mode_sgmii, 0);
    send_page(16'h0001);
    chk("R2 sgmii page flips to sgmii", mode_sgmii, 1);
    chk("R3 restart on autodet flip", restart_req, 1);
    chk("R4 chg flag on autodet flip", mode_chg_flag, 1);
    chk("R9 no capture on flip page", part_link, 0);
    tick();
    chk("R3 restart drops", restart_req, 0);
    send_page(16'h8001);
    chk("R2 matching page keeps mode", mode_sgmii, 1);
    chk("R3 no restart on match", restart_req, 0);
    chk("R7 link after autodet", part_link, 1);
    send_page(16'h0000);
    chk("R2 fiber page flips to fiber", mode_sgmii, 0);
    chk("R5 mismatch on flip page", sel_mis_flag, 1);
    chk("R9 fields cleared on flip", part_link, 0);
    fiber_cfg = 1'b0;
    tick(); tick();
    chk("R2 cfg ignored under autodet", mode_sgmii, 0);
    send_page(16'h0000);
    chk("R2 matching fiber page keeps mode", mode_sgmii, 0);
  endtask

  initial begin
    t_reset();
    t_cfg_mode();
    t_clear();
    t_decode();
    t_fiber();
    t_autodet();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule